// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Copy Engine

The block copies a run of equal-width items from one memory region to another. Software programs a start address for each side, a number of items and a control word, then sets the enable bit. The engine then loops over a read from the source, a write of that value to the destination and an update of its own registers. The update advances each address by the item width (or holds it, per side) and lowers the remaining count by one. When the count reaches zero it raises a sticky end flag, which drives an interrupt when that is allowed.

The register window has four 32-bit words selected by a 2-bit index. All registers can be read back at any time, so software can watch the addresses and the count move. The master port is a single request/acknowledge handshake. The engine holds the request, the address and the direction until the target acknowledges, and read data is taken in the cycle of the acknowledge.

Top module: `dmaChannel`

## Requirements
- R1: After reset every register reads 0, `mReq` is 0 and `irq` is 0.
- R2: Index 0 is the source address and index 1 the destination address, both 32-bit read/write. Index 2 is the item count: bits 23:0 are writable and the upper bits read 0. Index 3 is control: bit 0 enable, bits 2:1 item size, bit 3 source increment, bit 4 destination increment, bit 5 interrupt enable, bit 8 end flag.
- R3: A run starts only from idle, and only with enable=1, end flag=0 and a size code other than 11. The size codes are 00 = 1 byte, 01 = 2 bytes and 10 = 4 bytes. With code 11 no request is ever issued, and a set end flag also blocks any restart.
- R4: Each item is a read at the source address (`mWe`=0), then a write at the destination address (`mWe`=1). A request and its address stay unchanged until `mAck`. The write data is the read data with every bit above the item width forced to 0.
- R5: After each item, a side whose increment bit is 1 advances by the item width in bytes. A side whose bit is 0 keeps its address.
- R6: The count drops by one after each item. The update that brings it to 0 sets the end flag and returns the engine to idle. A programmed count of 0 reads 0xFFFFFF after the first item and runs 2^24 items.
- R7: The end flag clears only when software writes control with bit 8 = 0; writing 1 there changes nothing. When the hardware set and a software clear meet in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while the end flag and the interrupt enable are both 1.
- R9: If software clears enable during a run, the item in progress is completed and the engine then goes idle without setting the end flag. The addresses and the count keep the progress made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on regSel |
| mReq | output | 1 | Master request |
| mWe | output | 1 | Master direction, 1 = write |
| mAddr | output | 32 | Master byte address |
| mSize | output | 2 | Item size code |
| mWrData | output | 32 | Master write data |
| mAck | input | 1 | Target acknowledge |
| mRdData | input | 32 | Target read data, valid with mAck |
| irq | output | 1 | Interrupt |

## Verification
Two things can land on the end flag in the same clock: the hardware set from the final update, and a software write of control that clears it. The bench makes the target acknowledge at once, which fixes the cycle in which the last update takes effect. It then places a control write with bit 8 = 0 on exactly that edge. The flag and `irq` must still read 1 afterwards, and no new run may start. A clear issued on any other cycle must take effect, which separates a set-wins rule from one that lets software win.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_SRC = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DST = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CNT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTL = 2'd3;

  localparam int EN_BIT     = 0;
  localparam int SIZE_LSB   = 1;
  localparam int SRCINC_BIT = 3;
  localparam int DSTINC_BIT = 4;
  localparam int IRQEN_BIT  = 5;
  localparam int DONE_BIT   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } itemSize_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_UPDATE
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic selDst;
    logic captureData;
    logic advance;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic enable;
    logic sizeOk;
    logic done;
    logic lastItem;
  } chanStatus_t;
endpackage

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  seqStrobe_t        strobe,
  output chanStatus_t       status,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWrData,
  input  logic [DATA_W-1:0] mRdData,
  output logic              irq,
  output logic [CNT_W-1:0]  remaining
);
  localparam int SIDES = 2;

  logic              ctrlEn;
  itemSize_t         ctrlSize;
  logic [SIDES-1:0]  ctrlInc;
  logic              ctrlIrqEn;
  logic              ctrlDone;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] itemMask;
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] addrNow [SIDES];
  logic              wrCtl;
  logic              wrCnt;
  logic              setDone;

  assign wrCtl   = regWrEn && (regSel == SEL_CTL);
  assign wrCnt   = regWrEn && (regSel == SEL_CNT);
  assign setDone = strobe.advance && status.lastItem;

  always_comb begin
    case (ctrlSize)
      SZ_BYTE: begin stepBytes = ADDR_W'(1); itemMask = DATA_W'(8'hFF);    end
      SZ_HALF: begin stepBytes = ADDR_W'(2); itemMask = DATA_W'(16'hFFFF); end
      default: begin stepBytes = ADDR_W'(4); itemMask = '1;                end
    endcase
  end

  // one address register per side; the side index matches its select code
  for (genvar g = 0; g < SIDES; g++) begin : gSide
    logic [ADDR_W-1:0] addrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        addrQ <= '0;
      else if (regWrEn && (regSel == SEL_W'(g)))
        addrQ <= regWrData[ADDR_W-1:0];
      else if (strobe.advance && ctrlInc[g])
        addrQ <= addrQ + stepBytes;
    end
    assign addrNow[g] = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      countQ <= '0;
    else if (wrCnt)
      countQ <= regWrData[CNT_W-1:0];
    else if (strobe.advance)
      countQ <= countQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      ctrlSize  <= SZ_BYTE;
      ctrlInc   <= '0;
      ctrlIrqEn <= 1'b0;
      ctrlDone  <= 1'b0;
    end else begin
      if (wrCtl) begin
        ctrlEn    <= regWrData[EN_BIT];
        ctrlSize  <= itemSize_t'(regWrData[SIZE_LSB +: 2]);
        ctrlInc   <= {regWrData[DSTINC_BIT], regWrData[SRCINC_BIT]};
        ctrlIrqEn <= regWrData[IRQEN_BIT];
      end
      // hardware completion outranks a same-cycle software clear
      if (setDone)
        ctrlDone <= 1'b1;
      else if (wrCtl && !regWrData[DONE_BIT])
        ctrlDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dataQ <= '0;
    else if (strobe.captureData)
      dataQ <= mRdData;
  end

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_SRC: regRdData = REG_W'(addrNow[0]);
      SEL_DST: regRdData = REG_W'(addrNow[1]);
      SEL_CNT: regRdData = REG_W'(countQ);
      default: begin
        regRdData[EN_BIT]          = ctrlEn;
        regRdData[SIZE_LSB +: 2]   = ctrlSize;
        regRdData[SRCINC_BIT]      = ctrlInc[0];
        regRdData[DSTINC_BIT]      = ctrlInc[1];
        regRdData[IRQEN_BIT]       = ctrlIrqEn;
        regRdData[DONE_BIT]        = ctrlDone;
      end
    endcase
  end

  assign mAddr     = strobe.selDst ? addrNow[1] : addrNow[0];
  assign mSize     = ctrlSize;
  assign mWrData   = dataQ & itemMask;
  assign irq       = ctrlDone & ctrlIrqEn;
  assign remaining = countQ;

  assign status.enable   = ctrlEn;
  assign status.sizeOk   = (ctrlSize != SZ_RSVD);
  assign status.done     = ctrlDone;
  assign status.lastItem = (countQ == CNT_W'(1));
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mAck,
  input  chanStatus_t status,
  output seqStrobe_t  strobe,
  output logic        mReq,
  output logic        mWe
);
  seqState_t state;
  seqState_t nextState;
  logic      startOk;

  assign startOk = status.enable && status.sizeOk && !status.done;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (startOk) nextState = ST_READ;
      ST_READ:   if (mAck) nextState = ST_WRITE;
      ST_WRITE:  if (mAck) nextState = ST_UPDATE;
      ST_UPDATE: begin
        if (status.lastItem || !status.enable)
          nextState = ST_IDLE;
        else
          nextState = ST_READ;
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= ST_IDLE;
    else
      state <= nextState;
  end

  assign mReq               = (state == ST_READ) || (state == ST_WRITE);
  assign mWe                = (state == ST_WRITE);
  assign strobe.selDst      = (state == ST_WRITE);
  assign strobe.captureData = (state == ST_READ) && mAck;
  assign strobe.advance     = (state == ST_UPDATE);
endmodule

// File: rtl/dmaChannel.sv
module dmaChannel
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              mReq,
  output logic              mWe,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWrData,
  input  logic              mAck,
  input  logic [DATA_W-1:0] mRdData,
  output logic              irq
);
  seqStrobe_t       seqStb;
  chanStatus_t      dpStat;
  logic [CNT_W-1:0] remaining;

  dmaCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .mAck   (mAck),
    .status (dpStat),
    .strobe (seqStb),
    .mReq   (mReq),
    .mWe    (mWe)
  );

  dmaDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (seqStb),
    .status    (dpStat),
    .mAddr     (mAddr),
    .mSize     (mSize),
    .mWrData   (mWrData),
    .mRdData   (mRdData),
    .irq       (irq),
    .remaining (remaining)
  );
endmodule

// File: rtl/dmaChannelChk.sv
module dmaChannelChk
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [SEL_W-1:0]  regSel,
  input logic [REG_W-1:0]  regWrData,
  input logic              mReq,
  input logic              mWe,
  input logic [ADDR_W-1:0] mAddr,
  input logic [1:0]        mSize,
  input logic [DATA_W-1:0] mWrData,
  input logic              mAck,
  input logic              irq,
  input logic              doneFlag,
  input logic [CNT_W-1:0]  remaining
);
  logic [DATA_W-1:0] widthMask;
  logic              swClear;

  always_comb begin
    case (mSize)
      2'b00:   widthMask = DATA_W'(8'hFF);
      2'b01:   widthMask = DATA_W'(16'hFFFF);
      default: widthMask = '1;
    endcase
  end

  assign swClear = regWrEn && (regSel == SEL_CTL) && !regWrData[DONE_BIT];

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    mReq && !mAck |=> mReq && $stable(mWe) && $stable(mAddr));

  assert_wdata_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    mReq && mWe |-> (mWrData & ~widthMask) == '0);

  assert_no_rsvd_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> mSize != 2'b11);

  assert_done_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> remaining == '0);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !swClear |=> doneFlag);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);
endmodule

bind dmaChannel dmaChannelChk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .mReq      (mReq),
  .mWe       (mWe),
  .mAddr     (mAddr),
  .mSize     (mSize),
  .mWrData   (mWrData),
  .mAck      (mAck),
  .irq       (irq),
  .doneFlag  (dpStat.done),
  .remaining (remaining)
);

// File: tb/dmaChannel_tb_top.sv
module dmaChannel_tb_top;
  import dmaPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mReq, mWe;
  logic [31:0] mAddr;
  logic [1:0]  mSize;
  logic [31:0] mWrData;
  logic        mAck = 1'b0;
  logic [31:0] mRdData = '0;
  logic        irq;

  always #10 clk = ~clk;

  dmaChannel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mReq(mReq), .mWe(mWe),
    .mAddr(mAddr), .mSize(mSize), .mWrData(mWrData), .mAck(mAck),
    .mRdData(mRdData), .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;
  bit fastAck = 1'b0;
  int reqCycles = 0;
  int writesSeen = 0;
  logic [31:0] expRd = '0, expWr = '0, stepS = '0, stepD = '0;
  logic [31:0] expMask = '1, lastRead = '0;
  logic [1:0]  expSize = 2'd0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] stepFor(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] maskFor(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] ctlWord(input bit en, input logic [1:0] sz,
                                          input bit iS, input bit iD, input bit ie,
                                          input bit dn);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[2:1] = sz; w[3] = iS; w[4] = iD; w[5] = ie; w[8] = dn;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  // target model: answers at the falling edge, checks every transaction
  initial begin
    forever begin
      @(negedge clk);
      if (mReq) reqCycles++;
      if (mReq && (fastAck || ($urandom % 3 != 0))) begin
        mAck = 1'b1;
        if (!mWe) begin
          chk(mAddr == expRd, "R5", "read address", mAddr, expRd);
          chk(mSize == expSize, "R4", "item size", {30'd0, mSize}, {30'd0, expSize});
          lastRead = pat(mAddr);
          mRdData  = lastRead;
        end else begin
          chk(mAddr == expWr, "R5", "write address", mAddr, expWr);
          chk(mWrData == (lastRead & expMask), "R4", "write data", mWrData,
              lastRead & expMask);
          expRd = expRd + stepS;
          expWr = expWr + stepD;
          writesSeen++;
        end
      end else begin
        mAck    = 1'b0;
        mRdData = $urandom;
      end
    end
  end

  task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic [1:0] sz,
                       input bit iS, input bit iD);
    stepS = iS ? stepFor(sz) : 32'd0;
    stepD = iD ? stepFor(sz) : 32'd0;
    expRd = src; expWr = dst; expMask = maskFor(sz); expSize = sz;
    writesSeen = 0;
    regWrite(SEL_SRC, src);
    regWrite(SEL_DST, dst);
    regWrite(SEL_CNT, cnt);
  endtask

  task automatic runCase(input logic [31:0] src, input logic [31:0] dst,
                         input int cnt, input logic [1:0] sz,
                         input bit iS, input bit iD, input bit ie);
    logic [31:0] v;
    setup(src, dst, cnt, sz, iS, iD);
    regWrite(SEL_CTL, ctlWord(1'b1, sz, iS, iD, ie, 1'b0));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regRead(SEL_CTL, v);
      if (v[8]) break;
    end
    chk(v[8] == 1'b1, "R6", "end flag after run", {31'd0, v[8]}, 32'd1);
    regRead(SEL_CNT, v);
    chk(v == 32'd0, "R6", "count after run", v, 32'd0);
    chk(writesSeen == cnt, "R6", "items moved", writesSeen, cnt);
    regRead(SEL_SRC, v);
    chk(v == src + cnt * stepS, "R5", "final source", v, src + cnt * stepS);
    regRead(SEL_DST, v);
    chk(v == dst + cnt * stepD, "R5", "final destination", v, dst + cnt * stepD);
    chk(irq == ie, "R8", "irq after run", {31'd0, irq}, {31'd0, ie});
    chk(mReq == 1'b0, "R6", "idle after run", {31'd0, mReq}, 32'd0);
    regWrite(SEL_CTL, 32'd0);
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R7", "clear by writing 0", {31'd0, v[8]}, 32'd0);
    chk(irq == 1'b0, "R8", "irq after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snap;
    void'($urandom(32'd13579));

    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      regRead(2'(s), v);
      chk(v == 32'd0, "R1", "register after reset", v, 32'd0);
    end
    chk(mReq == 1'b0, "R1", "mReq after reset", {31'd0, mReq}, 32'd0);
    chk(irq == 1'b0, "R1", "irq after reset", {31'd0, irq}, 32'd0);

    // R2 register map read-back
    regWrite(SEL_SRC, 32'hDEAD_BEEF);
    regRead(SEL_SRC, v);
    chk(v == 32'hDEAD_BEEF, "R2", "source readback", v, 32'hDEAD_BEEF);
    regWrite(SEL_DST, 32'h1234_5678);
    regRead(SEL_DST, v);
    chk(v == 32'h1234_5678, "R2", "destination readback", v, 32'h1234_5678);
    regWrite(SEL_CNT, 32'hFFFF_FFFF);
    regRead(SEL_CNT, v);
    chk(v == 32'h00FF_FFFF, "R2", "count readback", v, 32'h00FF_FFFF);
    regWrite(SEL_CTL, ctlWord(1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0));
    regRead(SEL_CTL, v);
    chk(v == 32'h0000_003E, "R2", "control readback", v, 32'h0000_003E);
    regWrite(SEL_CTL, 32'd0);

    // R7 writing 1 to a clear end flag does nothing
    regWrite(SEL_CTL, ctlWord(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R7", "write 1 to clear flag", {31'd0, v[8]}, 32'd0);
    chk(irq == 1'b0, "R8", "irq with flag clear", {31'd0, irq}, 32'd0);
    regWrite(SEL_CTL, 32'd0);

    // R3 reserved size never starts
    setup(32'h100, 32'h200, 32'd3, 2'd3, 1'b1, 1'b1);
    snap = reqCycles;
    regWrite(SEL_CTL, ctlWord(1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (20) @(negedge clk);
    chk(reqCycles == snap, "R3", "requests with reserved size", reqCycles, snap);
    regRead(SEL_CNT, v);
    chk(v == 32'd3, "R3", "count with reserved size", v, 32'd3);
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R3", "flag with reserved size", {31'd0, v[8]}, 32'd0);
    regWrite(SEL_CTL, 32'd0);

    // directed runs, then random runs with random acknowledge delay
    runCase(32'h0000_0040, 32'h0000_0080, 1, 2'd0, 1'b0, 1'b0, 1'b1);
    runCase(32'h0000_1000, 32'h0000_2000, 5, 2'd2, 1'b1, 1'b0, 1'b0);
    runCase(32'h0000_3002, 32'h0000_4000, 4, 2'd1, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 12; k++) begin
      logic [1:0] sz;
      logic [31:0] al;
      sz = 2'($urandom % 3);
      al = ~(stepFor(sz) - 32'd1);
      runCase(($urandom & 32'h00FF_FFF0) & al, ($urandom & 32'h00FF_FFF0) & al,
              1 + int'($urandom % 6), sz, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R7 hardware set meets software clear on the same edge
    fastAck = 1'b1;
    setup(32'h500, 32'h600, 32'd1, 2'd0, 1'b1, 1'b1);
    regWrite(SEL_CTL, ctlWord(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (3) @(posedge clk);
    regWrite(SEL_CTL, ctlWord(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b1, "R7", "set wins over same-cycle clear", {31'd0, v[8]}, 32'd1);
    chk(irq == 1'b1, "R8", "irq after collision", {31'd0, irq}, 32'd1);
    chk(writesSeen == 1, "R6", "items in collision run", writesSeen, 1);
    snap = reqCycles;
    repeat (10) @(negedge clk);
    chk(reqCycles == snap, "R3", "no restart while flag set", reqCycles, snap);
    regWrite(SEL_CTL, ctlWord(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b1, "R7", "write 1 keeps flag", {31'd0, v[8]}, 32'd1);
    regWrite(SEL_CTL, 32'd0);
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R7", "clear after collision", {31'd0, v[8]}, 32'd0);

    // R6 count 0 means 2^24; R9 abort by clearing enable
    setup(32'h1000, 32'h2000, 32'd0, 2'd2, 1'b1, 1'b1);
    regWrite(SEL_CTL, ctlWord(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (4) @(posedge clk);
    @(negedge clk);
    regRead(SEL_CNT, v);
    chk(v == 32'h00FF_FFFF, "R6", "count 0 after one item", v, 32'h00FF_FFFF);
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R6", "no flag on count 0 run", {31'd0, v[8]}, 32'd0);
    regWrite(SEL_CTL, ctlWord(1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (20) @(negedge clk);
    chk(mReq == 1'b0, "R9", "idle after disable", {31'd0, mReq}, 32'd0);
    regRead(SEL_CNT, v);
    chk(v == ((32'h0100_0000 - writesSeen) & 32'h00FF_FFFF), "R9", "count kept",
        v, (32'h0100_0000 - writesSeen) & 32'h00FF_FFFF);
    regRead(SEL_SRC, v);
    chk(v == 32'h1000 + 4 * writesSeen, "R9", "source kept", v, 32'h1000 + 4 * writesSeen);
    regRead(SEL_CTL, v);
    chk(v[8] == 1'b0, "R9", "no flag after abort", {31'd0, v[8]}, 32'd0);
    chk(irq == 1'b0, "R9", "no irq after abort", {31'd0, irq}, 32'd0);

    summary();
    $finish;
  end
endmodule